// File: doc/BRIEF.md
# Four-Channel Edge-Match PWM Generator

This block produces four pulse-width-modulated waveforms from one shared 16-bit down-counter. The counter steps only on cycles where a clock enable is high, so an external prescaler sets the time base. Each time the counter passes 1 it starts again from a programmable reload value. Each channel has two 16-bit match values. A rise value sets the channel's true output when the count reaches it, and a fall value clears the output when the count reaches it. A channel compares the count against only one of these values at a time, chosen by the level its output has now. When the two values are equal, the output therefore toggles once per counter cycle.

Each channel also drives a complementary output. That output is active only when both a global pair-enable bit and the channel's own enable are set, and it is held Low otherwise. Software programs the block through a byte-wide write strobe.

A 16-bit value is written as two bytes. The low byte is held in a staging byte and has no effect until the high byte arrives. The high-byte write then commits both bytes together, so a compare can never see half of an old value and half of a new one.

Each channel is a two-state machine with the states SEEK_RISE (output Low, compares against the rise value) and SEEK_FALL (output High, compares against the fall value). It has three transitions:
- RISE_HIT: SEEK_RISE to SEEK_FALL, on an enabled count step whose count equals the rise value.
- FALL_HIT: SEEK_FALL to SEEK_RISE, on an enabled count step whose count equals the fall value.
- DISABLE: any state to SEEK_RISE, whenever the channel enable is 0.

Top module: `mpwm_top`

## Requirements
- R1: When `cnt_en` is 1, the count decreases by one on each clock. If the count is 1 (or 0), the next step loads the reload register instead. After reset the count equals the reset reload value, 12.
- R2: While `cnt_en` is 0, the count and every channel output keep their values.
- R3: An enabled channel in SEEK_RISE moves to SEEK_FALL (true output High) on an enabled step whose count equals its rise value. In SEEK_FALL it moves back to SEEK_RISE (true output Low) on an enabled step whose count equals its fall value. Only the value that belongs to the present state is compared. Over one counter cycle of length L, the output is High for rise−fall steps when rise > fall, and for L−(fall−rise) steps when rise < fall.
- R4: When a channel's rise and fall values are equal, its true output toggles exactly once per counter cycle.
- R5: After reset, all four channel enables and the pair enable are 1, all match values are 0, every true output is Low and every complementary output is High.
- R6: `pwm_out_n[c]` equals the inverse of `pwm_out[c]` when the pair enable (control bit 4) and channel enable bit c are both 1. Otherwise it is 0.
- R7: A disabled channel drives both of its outputs Low and returns to SEEK_RISE. After it is re-enabled, its true output is Low until the next rise match.
- R8: A write to a low-byte address only stages that byte. The 16-bit value changes only when the matching high-byte address is written, and it then takes {high byte, staged low byte}.
- R9: The address map is as follows. For channel c, address 4c+0 is the rise low byte, 4c+1 the rise high byte, 4c+2 the fall low byte and 4c+3 the fall high byte. Address 0x10 is control: bits 3:0 are the channel enables and bit 4 is the pair enable. Address 0x12 is the reload low byte and 0x13 the reload high byte.
- R10: A new reload value is used at the next wrap from 1. It does not change the count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 4 | True PWM outputs, one per channel |
| pwm_out_n | output | 4 | Gated complementary outputs |
| count_o | output | 16 | Present value of the shared down-counter |

## Verification
The bench measures high time over whole counter cycles for several rise and fall pairs: rise above fall, rise below fall, values at the extremes 1 and 12, and equal values. A design that compared both values at once, or that swapped the two, would report the wrong high-step count. It checks that staged low bytes stay inert, which catches a design that tears its compare value on the first byte. It freezes `cnt_en` in the middle of a pulse to catch a match that fires on a held count. It disables a channel while its output is High to catch edge state that survives a disable. It also checks that a new reload value takes effect only at the next wrap, and that the complementary outputs are gated by the pair enable and by each channel enable.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
    localparam int NUM_CH         = 4;
    localparam int BYTE_W         = 8;
    localparam int CNT_W          = 2 * BYTE_W;
    localparam int CH_SEL_W       = $clog2(NUM_CH);
    localparam int CTRL_ADDR      = 4 * NUM_CH;
    localparam int RELOAD_LO_ADDR = CTRL_ADDR + 2;
    localparam int RELOAD_HI_ADDR = CTRL_ADDR + 3;
    localparam int ADDR_W         = $clog2(CTRL_ADDR + 4);

    typedef enum logic {
        SEEK_RISE = 1'b0,
        SEEK_FALL = 1'b1
    } edge_state_e;
endpackage

// File: rtl/mpwm_counter.sv
module mpwm_counter
    import mpwm_pkg::*;
#(
    parameter int RELOAD_RST = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RELOAD_RST);
        end else if (cnt_en) begin
            if (count_q <= CNT_W'(1)) count_q <= reload;
            else                      count_q <= count_q - CNT_W'(1);
        end
    end

    assign count = count_q;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count_q)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count_q > CNT_W'(1)) |=> (count_q == $past(count_q) - CNT_W'(1))); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && count_q <= CNT_W'(1)) |=> (count_q == $past(reload))); // R10
endmodule

// File: rtl/mpwm_regs.sv
module mpwm_regs
    import mpwm_pkg::*;
#(
    parameter int RELOAD_RST = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [NUM_CH-1:0][CNT_W-1:0] rise_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] fall_o,
    output logic [NUM_CH-1:0]            ch_en_o,
    output logic                         pair_en_o,
    output logic [CNT_W-1:0]             reload_o
);
    logic [NUM_CH-1:0][CNT_W-1:0]       rise_q, fall_q;
    logic [NUM_CH-1:0][1:0][BYTE_W-1:0] stage_q;
    logic [BYTE_W-1:0]                  rl_stage_q;
    logic [NUM_CH-1:0]                  en_q;
    logic                               pair_q;
    logic [CNT_W-1:0]                   reload_q;

    logic                edge_sel, fall_sel, hi_sel;
    logic [CH_SEL_W-1:0] ch_sel;

    always_comb begin
        edge_sel = (wr_addr < ADDR_W'(CTRL_ADDR));
        ch_sel   = wr_addr[CH_SEL_W+1:2];
        fall_sel = wr_addr[1];
        hi_sel   = wr_addr[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q     <= '0;
            fall_q     <= '0;
            stage_q    <= '0;
            rl_stage_q <= '0;
            en_q       <= '1;
            pair_q     <= 1'b1;
            reload_q   <= CNT_W'(RELOAD_RST);
        end else if (wr_en) begin
            if (edge_sel) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (ch_sel == CH_SEL_W'(c)) begin
                        if (!hi_sel)       stage_q[c][fall_sel] <= wr_data;
                        else if (fall_sel) fall_q[c] <= {wr_data, stage_q[c][1]};
                        else               rise_q[c] <= {wr_data, stage_q[c][0]};
                    end
                end
            end else if (wr_addr == ADDR_W'(CTRL_ADDR)) begin
                en_q   <= wr_data[NUM_CH-1:0];
                pair_q <= wr_data[NUM_CH];
            end else if (wr_addr == ADDR_W'(RELOAD_LO_ADDR)) begin
                rl_stage_q <= wr_data;
            end else if (wr_addr == ADDR_W'(RELOAD_HI_ADDR)) begin
                reload_q <= {wr_data, rl_stage_q};
            end
        end
    end

    assign rise_o    = rise_q;
    assign fall_o    = fall_q;
    assign ch_en_o   = en_q;
    assign pair_en_o = pair_q;
    assign reload_o  = reload_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_stage_chk
        AST_RISE_LO_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && edge_sel && !hi_sel && !fall_sel && ch_sel == CH_SEL_W'(g))
            |=> $stable(rise_q[g])); // R8
        AST_FALL_LO_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && edge_sel && !hi_sel && fall_sel && ch_sel == CH_SEL_W'(g))
            |=> $stable(fall_q[g])); // R8
    end
endmodule

// File: rtl/mpwm_channel.sv
module mpwm_channel
    import mpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] rise_val,
    input  logic [CNT_W-1:0] fall_val,
    input  logic             en,
    input  logic             pair_en,
    output logic             pwm_p,
    output logic             pwm_n
);
    edge_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = SEEK_RISE;                       // DISABLE
        end else if (cnt_en) begin
            unique case (state_q)
                SEEK_RISE: if (count == rise_val) state_d = SEEK_FALL; // RISE_HIT
                SEEK_FALL: if (count == fall_val) state_d = SEEK_RISE; // FALL_HIT
                default:   state_d = SEEK_RISE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEEK_RISE;
        else        state_q <= state_d;
    end

    always_comb begin
        pwm_p = en && (state_q == SEEK_FALL);
        pwm_n = (en && pair_en) ? !pwm_p : 1'b0;
    end

    AST_DIS_SEEK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == SEEK_RISE)); // R7
    AST_HELD_COUNT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cnt_en) |=> $stable(state_q)); // R2
    AST_RISE_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEEK_RISE && count != rise_val) |=> (state_q == SEEK_RISE)); // R3
    AST_FALL_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == SEEK_FALL && count != fall_val) |=> (state_q == SEEK_FALL)); // R3
endmodule

// File: rtl/mpwm_top.sv
module mpwm_top
    import mpwm_pkg::*;
#(
    parameter int RELOAD_RST = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_out_n,
    output logic [CNT_W-1:0]  count_o
);
    logic [NUM_CH-1:0][CNT_W-1:0] rise_v, fall_v;
    logic [NUM_CH-1:0]            ch_en;
    logic                         pair_en;
    logic [CNT_W-1:0]             reload_v;
    logic [CNT_W-1:0]             count_v;

    mpwm_regs #(.RELOAD_RST(RELOAD_RST)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rise_o(rise_v), .fall_o(fall_v),
        .ch_en_o(ch_en), .pair_en_o(pair_en), .reload_o(reload_v)
    );

    mpwm_counter #(.RELOAD_RST(RELOAD_RST)) cnt_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .reload(reload_v), .count(count_v)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mpwm_channel ch_i (
            .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .count(count_v),
            .rise_val(rise_v[g]), .fall_val(fall_v[g]),
            .en(ch_en[g]), .pair_en(pair_en),
            .pwm_p(pwm_out[g]), .pwm_n(pwm_out_n[g])
        );
    end

    assign count_o = count_v;

    AST_COMP_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_en |-> (pwm_out_n == '0)); // R6
    AST_COMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & pwm_out_n) == '0)); // R6
endmodule

// File: tb/mpwm_top_tb_top.sv
module mpwm_top_tb_top;
    localparam int CLK_NS = 4;
    localparam int L      = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  pwm_out, pwm_out_n;
    logic [15:0] count_o;

    int checks = 0;
    int errors = 0;
    logic [4:0] ctrl_sh = 5'h1F;

    always #(CLK_NS/2) clk = ~clk;

    mpwm_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out),
        .pwm_out_n(pwm_out_n), .count_o(count_o)
    );

    // {rise, fall, expected high steps over two counter cycles}
    localparam logic [47:0] VEC [0:6] = '{
        {16'd9,  16'd3,  16'd12},
        {16'd3,  16'd10, 16'd10},
        {16'd12, 16'd1,  16'd22},
        {16'd5,  16'd5,  16'd12},
        {16'd7,  16'd6,  16'd2},
        {16'd2,  16'd11, 16'd6},
        {16'd1,  16'd12, 16'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input logic [4:0] v);
        ctrl_sh = v;
        wr(16, int'(v));
    endtask

    task automatic program_ch(input int ch, input int rise, input int fall);
        set_ctrl(ctrl_sh & ~(5'd1 << ch));
        wr(4*ch + 0, rise & 8'hFF);
        wr(4*ch + 1, rise >> 8);
        wr(4*ch + 2, fall & 8'hFF);
        wr(4*ch + 3, fall >> 8);
        set_ctrl(ctrl_sh | (5'd1 << ch));
    endtask

    task automatic measure(input int ch, input int n, output int highs, output int mism);
        highs = 0; mism = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            highs += int'(pwm_out[ch]);
            if (pwm_out_n[ch] !== ~pwm_out[ch]) mism++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi, mm, prev, tr, waited;
        logic last, cur;
        logic [15:0] c0;
        logic [3:0]  p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        check(pwm_out == 4'h0, "R5 pwm_out", int'(pwm_out), 0);
        check(pwm_out_n == 4'hF, "R5 pwm_out_n", int'(pwm_out_n), 15);
        check(count_o == 16'd12, "R5 R1 count", int'(count_o), 12);

        // R1 down-count with wrap to reload
        cnt_en = 1'b1;
        prev = int'(count_o);
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            check(int'(count_o) == ((prev <= 1) ? L : prev - 1), "R1 step",
                  int'(count_o), (prev <= 1) ? L : prev - 1);
            prev = int'(count_o);
        end

        // R3 R9 vector table, complement check R6
        for (int i = 0; i < 7; i++) begin
            program_ch(i % 4, int'(VEC[i][47:32]), int'(VEC[i][31:16]));
            idle(2*L);
            measure(i % 4, 2*L, hi, mm);
            check(hi == int'(VEC[i][15:0]), "R3 R9 high steps", hi, int'(VEC[i][15:0]));
            check(mm == 0, "R6 complement", mm, 0);
        end

        // R4 equal values toggle once per cycle
        program_ch(1, 5, 5);
        idle(2*L);
        @(negedge clk);
        last = pwm_out[1]; tr = 0;
        for (int k = 0; k < 2*L; k++) begin
            @(negedge clk);
            cur = pwm_out[1];
            if (cur != last) tr++;
            last = cur;
        end
        check(tr == 2, "R4 toggles", tr, 2);

        // R8 staged low byte
        program_ch(0, 9, 3);
        idle(2*L);
        measure(0, 2*L, hi, mm);
        check(hi == 12, "R8 baseline", hi, 12);
        wr(0, 5);
        idle(2*L);
        measure(0, 2*L, hi, mm);
        check(hi == 12, "R8 low byte alone inert", hi, 12);
        wr(1, 0);
        idle(2*L);
        measure(0, 2*L, hi, mm);
        check(hi == 4, "R8 commit on high byte", hi, 4);

        // R2 hold while output high
        waited = 0;
        while (!pwm_out[0] && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        cnt_en = 1'b0;
        @(negedge clk);
        c0 = count_o; p0 = pwm_out;
        idle(6);
        check(count_o == c0, "R2 count held", int'(count_o), int'(c0));
        check(pwm_out == p0 && p0[0], "R2 outputs held", int'(pwm_out), int'(p0));

        // R7 disable and re-enable
        set_ctrl(ctrl_sh & 5'b11110);
        check(pwm_out[0] == 1'b0 && pwm_out_n[0] == 1'b0, "R7 disabled low",
              int'({pwm_out[0], pwm_out_n[0]}), 0);
        set_ctrl(ctrl_sh | 5'b00001);
        idle(2);
        check(pwm_out[0] == 1'b0 && pwm_out_n[0] == 1'b1, "R7 back to seek rise",
              int'({pwm_out[0], pwm_out_n[0]}), 1);
        cnt_en = 1'b1;

        // R6 gating
        set_ctrl(5'h0F);
        mm = 0;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (pwm_out_n != 4'h0) mm++;
        end
        check(mm == 0, "R6 pair off", mm, 0);
        set_ctrl(5'h1B);
        mm = 0;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (pwm_out_n[2] !== 1'b0 || pwm_out[2] !== 1'b0) mm++;
            if (pwm_out_n[0] !== ~pwm_out[0]) mm++;
        end
        check(mm == 0, "R6 R7 per-channel gate", mm, 0);

        // R10 reload applies at next wrap
        wr(18, 6);
        wr(19, 0);
        check(count_o <= 16'd12, "R10 count not reloaded early", int'(count_o), 12);
        waited = 0;
        while (count_o != 16'd1 && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        @(negedge clk);
        check(count_o == 16'd6, "R10 wrap to new reload", int'(count_o), 6);
        @(negedge clk);
        check(count_o == 16'd5, "R10 R1 step after reload", int'(count_o), 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule